// File: doc/BRIEF.md
# Superframe Signalling Bit Stack (Transmit)

This block holds the five-byte signalling stack that a host loads for one 72-frame line superframe, and streams it out as a single serial bit, one bit for each signalling-frame slot. The host writes bytes through a simple address/data port into a holding copy. At every start-of-superframe pulse from the framer, the holding copy is transferred into a shadow copy that feeds the serializer. A ready flag is raised at that moment, which tells the host that the next update window has opened.

The serializer walks 36 bit positions. Each slot strobe from the framer advances it by one position. The output bit is forced low unless the stack is enabled and the mode field selects stack operation. If the host skips an update window, the next transfer copies the unchanged holding bytes, so the previous contents go out again. A read of the status address returns the ready flag and clears it. A new ready event in the same cycle takes priority over that clear.

Top module: `slc96_txstack`

## Requirements
- R1: While reset is asserted and directly after it, `stk_ready` is 0, `ser_bit` is 0 and all five holding bytes read as 0.
- R2: A write with `wr_addr` 0..4 stores `wr_data` into that holding byte, and it reads back on `rd_data` at the same address. Writes to addresses 5..7 change no holding byte, and reads of addresses 6..7 return 0.
- R3: Stack output is active only when `stack_en` is 1 and `mode[1:0]` is binary 10, with `mode[2]` a don't-care. In every other combination `ser_bit` is 0.
- R4: On a `sf_start` pulse the holding bytes are copied into the serializer. Writes made after that pulse do not reach `ser_bit` before the next `sf_start`.
- R5: Serial position k (0..35) carries bit 7-(k mod 8) of byte k/8, so bytes go out MSB first, from byte 0 to byte 4 upper nibble. `ser_bit` shows position k combinationally, and each `slot_stb` cycle advances to k+1.
- R6: After 36 strobes `ser_bit` stays 0, and further strobes have no effect until the next `sf_start`.
- R7: `stk_ready` becomes 1 in the cycle after a `sf_start` pulse.
- R8: Reading address 5 returns `stk_ready` in `rd_data` bit 0 and 0 in bits 7..1. A cycle with `rd_en` high at address 5 clears `stk_ready` from the next cycle on.
- R9: When a status-clearing read and `sf_start` occur in the same cycle, `stk_ready` is 1 afterwards.
- R10: If no write occurs between two `sf_start` pulses, the second superframe sends the same 36 bits as the first.
- R11: A `sf_start` that coincides with `slot_stb` restarts the serializer at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe (clears ready at status address) |
| rd_addr | input | 3 | Host read address; 5 is status |
| rd_data | output | 8 | Read data (combinational) |
| stack_en | input | 1 | Stack enable |
| mode | input | 3 | Data-link mode field; stack mode is x10 |
| sf_start | input | 1 | Start-of-superframe pulse from the framer |
| slot_stb | input | 1 | Signalling-slot strobe from the framer |
| ser_bit | output | 1 | Serial stack bit for line insertion |
| stk_ready | output | 1 | Stack ready status flag |

## Verification
Five stack patterns are streamed through full superframes: all zeros, all ones, a walking one per byte, alternating bytes and an arithmetic sequence. Together they separate stuck output bits, bit reversal inside a byte, byte misordering and a pointer off by one. A sweep of all sixteen enable/mode combinations with an all-ones stack checks the gating decode. A write made mid-superframe, followed by an unrefreshed superframe, tells the double buffering apart from a direct path, and shows whether old data is repeated. Status reads taken alone and together with a start pulse tell the clear-on-read path apart from the priority of the set.

// File: rtl/slc96_pkg.sv
package slc96_pkg;
  localparam int unsigned STK_BYTES   = 5;
  localparam int unsigned STK_BYTE_W  = 8;
  localparam int unsigned STK_ADDR_W  = 3;
  localparam int unsigned SF_SLOTS    = 36;
  localparam int unsigned MODE_W      = 3;
  localparam int unsigned STATUS_ADDR = 5;
  // mode[1:0] pattern that selects stack operation
  localparam logic [1:0]  MODE_STACK  = 2'b10;
endpackage

// File: rtl/slc96_hold_regs.sv
module slc96_hold_regs #(
  parameter int unsigned N  = 5,
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_byte,
  output logic [N*W-1:0] hold_flat
);
  logic [W-1:0] byte_q [N];
  logic [W-1:0] byte_d [N];

  for (genvar i = 0; i < N; i++) begin : g_byte
    always_comb begin
      byte_d[i] = byte_q[i];
      if (wr_en && (wr_addr == AW'(i))) byte_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[i] <= '0;
      else        byte_q[i] <= byte_d[i];
    end

    // byte 0 sits at the top of the flat vector so serial order is MSB-first
    assign hold_flat[(N-1-i)*W +: W] = byte_q[i];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_addr == AW'(i)) rd_byte = byte_q[i];
    end
  end
endmodule

// File: rtl/slc96_shadow_ser.sv
module slc96_shadow_ser #(
  parameter int unsigned N     = 5,
  parameter int unsigned W     = 8,
  parameter int unsigned SLOTS = 36,
  localparam int unsigned TOTAL = N * W,
  localparam int unsigned PW    = $clog2(SLOTS + 1),
  localparam int unsigned IW    = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stb,
  input  logic             active,
  input  logic [TOTAL-1:0] hold_flat,
  output logic             ser_bit,
  output logic [PW-1:0]    ptr
);
  logic [TOTAL-1:0] shadow_q, shadow_d;
  logic [PW-1:0]    ptr_q, ptr_d;
  logic             in_frame;
  logic [IW-1:0]    sel_idx;

  assign in_frame = (ptr_q < PW'(SLOTS));

  always_comb begin
    shadow_d = shadow_q;
    ptr_d    = ptr_q;
    if (load) begin
      shadow_d = hold_flat;
      ptr_d    = '0;
    end else if (stb && in_frame) begin
      ptr_d    = ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      ptr_q    <= PW'(SLOTS);
    end else begin
      shadow_q <= shadow_d;
      ptr_q    <= ptr_d;
    end
  end

  assign sel_idx = IW'(TOTAL - 1) - IW'(ptr_q);
  assign ser_bit = active && in_frame && shadow_q[sel_idx];
  assign ptr     = ptr_q;
endmodule

// File: rtl/slc96_ready_flag.sv
module slc96_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic ready
);
  logic ready_q, ready_d;

  always_comb begin
    ready_d = ready_q;
    if (set)      ready_d = 1'b1;
    else if (clr) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign ready = ready_q;
endmodule

// File: rtl/slc96_txstack.sv
module slc96_txstack
  import slc96_pkg::*;
#(
  parameter int unsigned N      = STK_BYTES,
  parameter int unsigned W      = STK_BYTE_W,
  parameter int unsigned AW     = STK_ADDR_W,
  parameter int unsigned SLOTS  = SF_SLOTS,
  parameter int unsigned MW     = MODE_W,
  parameter int unsigned ST_ADR = STATUS_ADDR,
  localparam int unsigned PW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          stack_en,
  input  logic [MW-1:0] mode,
  input  logic          sf_start,
  input  logic          slot_stb,
  output logic          ser_bit,
  output logic          stk_ready
);
  logic [N*W-1:0] hold_flat;
  logic [W-1:0]   rd_byte;
  logic           active;
  logic           status_sel;
  logic [PW-1:0]  slot_ptr;

  assign active     = stack_en && (mode[1:0] == MODE_STACK);
  assign status_sel = (rd_addr == AW'(ST_ADR));

  slc96_hold_regs #(.N(N), .W(W), .AW(AW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_byte   (rd_byte),
    .hold_flat (hold_flat)
  );

  slc96_shadow_ser #(.N(N), .W(W), .SLOTS(SLOTS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sf_start),
    .stb       (slot_stb),
    .active    (active),
    .hold_flat (hold_flat),
    .ser_bit   (ser_bit),
    .ptr       (slot_ptr)
  );

  slc96_ready_flag u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sf_start),
    .clr   (rd_en && status_sel),
    .ready (stk_ready)
  );

  always_comb begin
    if (rd_addr < AW'(N))  rd_data = rd_byte;
    else if (status_sel)   rd_data = {{(W-1){1'b0}}, stk_ready};
    else                   rd_data = '0;
  end
endmodule

// File: rtl/slc96_txstack_chk.sv
module slc96_txstack_chk #(
  parameter int unsigned AW     = 3,
  parameter int unsigned SLOTS  = 36,
  parameter int unsigned MW     = 3,
  parameter int unsigned ST_ADR = 5,
  localparam int unsigned PW    = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sf_start,
  input logic          slot_stb,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          stack_en,
  input logic [MW-1:0] mode,
  input logic          ser_bit,
  input logic          stk_ready,
  input logic [PW-1:0] slot_ptr
);
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> stk_ready); // R7
  AST_READY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == AW'(ST_ADR) && !sf_start) |=> !stk_ready); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == AW'(ST_ADR) && sf_start) |=> stk_ready); // R9
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(stack_en && mode[1:0] == 2'b10) |-> !ser_bit); // R3
  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> slot_ptr == '0); // R11
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sf_start && slot_stb && slot_ptr < PW'(SLOTS)) |=> slot_ptr == $past(slot_ptr) + PW'(1)); // R5
  AST_PTR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sf_start && slot_ptr == PW'(SLOTS)) |=> $stable(slot_ptr)); // R6
  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ptr == PW'(SLOTS)) |-> !ser_bit); // R6
endmodule

bind slc96_txstack slc96_txstack_chk #(
  .AW(AW), .SLOTS(SLOTS), .MW(MW), .ST_ADR(ST_ADR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sf_start  (sf_start),
  .slot_stb  (slot_stb),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .stack_en  (stack_en),
  .mode      (mode),
  .ser_bit   (ser_bit),
  .stk_ready (stk_ready),
  .slot_ptr  (slot_ptr)
);

// File: tb/tb_slc96_txstack.sv
module tb_slc96_txstack;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, stack_en, sf_start, slot_stb;
  logic [2:0] wr_addr, rd_addr, mode;
  logic [7:0] wr_data, rd_data;
  logic       ser_bit, stk_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_stk [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  slc96_txstack dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .stack_en(stack_en),
    .mode(mode), .sf_start(sf_start), .slot_stb(slot_stb), .ser_bit(ser_bit),
    .stk_ready(stk_ready)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h01 << i;
      3: return (i % 2 == 0) ? 8'hAA : 8'h55;
      default: return 8'(i * 37 + 11);
    endcase
  endfunction

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic sf_pulse(input logic with_read, input logic with_stb);
    @(negedge clk); sf_start = 1; rd_en = with_read; rd_addr = 3'd5; slot_stb = with_stb;
    @(negedge clk); sf_start = 0; rd_en = 0; slot_stb = 0;
  endtask

  task automatic strobe();
    @(negedge clk); slot_stb = 1;
    @(negedge clk); slot_stb = 0;
  endtask

  task automatic load_pattern(input int p);
    for (int i = 0; i < 5; i++) begin
      exp_stk[i] = pat(p, i);
      host_write(3'(i), exp_stk[i]);
    end
  endtask

  // R5: walk all 36 positions, then R6 quiet tail
  task automatic stream_check(input string req);
    for (int k = 0; k < 36; k++) begin
      chk({7'b0, ser_bit}, {7'b0, exp_stk[k/8][7 - (k % 8)]}, req);
      strobe();
    end
    chk({7'b0, ser_bit}, 8'h00, "R6 tail");
    strobe();
    chk({7'b0, ser_bit}, 8'h00, "R6 extra strobe");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] saved [5];
    rst_n = 0; wr_en = 0; rd_en = 0; stack_en = 1; sf_start = 0; slot_stb = 0;
    wr_addr = 0; rd_addr = 0; wr_data = 0; mode = 3'b010;
    repeat (3) @(negedge clk);
    chk({7'b0, stk_ready}, 8'h00, "R1 ready in reset");
    chk({7'b0, ser_bit}, 8'h00, "R1 ser in reset");
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      rd_addr = 3'(i); #1;
      chk(rd_data, 8'h00, "R1 holding byte");
    end
    chk({7'b0, stk_ready}, 8'h00, "R1 ready after reset");

    // R2: write/readback and ignored addresses
    load_pattern(4);
    host_write(3'd5, 8'hC3); host_write(3'd6, 8'h5A); host_write(3'd7, 8'hFF);
    for (int i = 0; i < 5; i++) begin
      rd_addr = 3'(i); #1;
      chk(rd_data, exp_stk[i], "R2 readback");
    end
    rd_addr = 3'd6; #1; chk(rd_data, 8'h00, "R2 addr6 reads 0");
    rd_addr = 3'd7; #1; chk(rd_data, 8'h00, "R2 addr7 reads 0");
    rd_addr = 3'd5; #1; chk(rd_data, 8'h00, "R8 status before any start");

    // R4/R5/R6 over pattern sweep
    for (int p = 0; p < 5; p++) begin
      load_pattern(p);
      sf_pulse(0, 0);
      chk({7'b0, stk_ready}, 8'h01, "R7 ready after start");
      stream_check("R5 serial bit");
    end

    // R10: no refresh -> same bits again (pattern 4 still in holding)
    sf_pulse(0, 0);
    stream_check("R10 retransmit");

    // R4: mid-superframe write not seen until next start
    load_pattern(2);
    sf_pulse(0, 0);
    for (int i = 0; i < 5; i++) saved[i] = exp_stk[i];
    for (int k = 0; k < 4; k++) strobe();
    for (int i = 0; i < 5; i++) host_write(3'(i), pat(3, i));
    for (int k = 4; k < 36; k++) begin
      chk({7'b0, ser_bit}, {7'b0, saved[k/8][7 - (k % 8)]}, "R4 old data kept");
      strobe();
    end
    for (int i = 0; i < 5; i++) exp_stk[i] = pat(3, i);
    sf_pulse(0, 0);
    stream_check("R4 new data after start");

    // R3: enable/mode sweep with all-ones stack at slot 0
    load_pattern(1);
    sf_pulse(0, 0);
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 8; m++) begin
        @(negedge clk); stack_en = e[0]; mode = 3'(m); #1;
        chk({7'b0, ser_bit}, {7'b0, (e == 1) && (m % 4 == 2)}, "R3 mode gating");
      end
    end
    stack_en = 1; mode = 3'b110;

    // R8: status read then clear
    rd_addr = 3'd5; #1;
    chk(rd_data, 8'h01, "R8 status read value");
    @(negedge clk); rd_en = 1; rd_addr = 3'd5;
    @(negedge clk); rd_en = 0;
    chk({7'b0, stk_ready}, 8'h00, "R8 cleared by read");
    #1; chk(rd_data, 8'h00, "R8 status reads 0");
    // reading a data address does not clear
    sf_pulse(0, 0);
    @(negedge clk); rd_en = 1; rd_addr = 3'd2;
    @(negedge clk); rd_en = 0;
    chk({7'b0, stk_ready}, 8'h01, "R8 data read keeps ready");
    @(negedge clk); rd_en = 1; rd_addr = 3'd5;
    @(negedge clk); rd_en = 0;
    chk({7'b0, stk_ready}, 8'h00, "R8 cleared again");

    // R9: same-cycle read and start -> set wins
    sf_pulse(1, 0);
    chk({7'b0, stk_ready}, 8'h01, "R9 set wins");

    // R11: start together with strobe restarts at slot 0
    load_pattern(2);
    sf_pulse(0, 0);
    for (int k = 0; k < 10; k++) strobe();
    sf_pulse(0, 1);
    stream_check("R11 restart at slot 0");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule